// File: doc/BRIEF.md
# First-Fit Queue Memory Page Allocator

This block manages a shared queue memory of 128 pages, each page sixteen dwords wide. It keeps a 128-bit page-occupancy bitmap and a table of 32-bit configuration words, one per queue. An allocate request names a queue, a length in dwords (16, 32, 64 or 128) and two 3-bit fill watermarks. The block then slides a run of 1, 2, 4 or 8 pages upward from page 0, testing one candidate start per clock. It takes the lowest start whose pages are all free, marks those pages used, stores the formatted configuration word for the queue and returns the start page. When the run no longer fits below the top of memory, it answers out-of-memory. A free request names a queue. The block reads that queue's stored word, decodes the start page and size code from it, clears those pages and zeroes the word.

Pages 0 to 3 are held for configuration. They are marked used at reset and are never handed out, so a stored configuration word is never zero. The control is a three-state machine. `S_IDLE` waits for `req_valid`. An allocate request that passes its checks moves to `S_SEARCH` (transition *start search*). Any other request goes straight to `S_DONE` (transition *decide at accept*). `S_SEARCH` stays put and steps the candidate (transition *step*) until it either finds a fit (transition *commit*) or runs past the end (transition *exhausted*). Both of those lead to `S_DONE`. `S_DONE` always returns to `S_IDLE` (transition *retire*).

Top module: `qpa_alloc`

## Requirements
- R1: After reset `busy` and `done` are low, no queue holds a configuration word, and pages 0 to 3 are occupied, so the first 16-dword allocation returns page 4.
- R2: Lengths 16, 32, 64 and 128 dwords map to size codes 0, 1, 2 and 3, which occupy 1, 2, 4 and 8 consecutive pages. Any other length gets error code 1 (invalid), with `done` seen in the first cycle after the accepting edge and no search.
- R3: An allocation whose nearly-empty or nearly-full watermark is above 7 gets error code 1 (invalid) and changes no state.
- R4: The allocation takes the lowest start page whose whole run is free. Candidates are tested in ascending order, one per clock, so `done` appears in cycle start+2 after the accepting edge.
- R5: When no free run exists, the result is error code 3 (out-of-memory). The bitmap stays as it was, and a run is never placed so that start + pages exceeds 128.
- R6: On success, `rsp_cfg` and the stored word hold the nearly-full watermark in bits 31:29, the nearly-empty watermark in bits 28:26, the size code in bits 25:24 and the start page in bits 21:14, with every other bit zero.
- R7: An allocation for a queue whose stored word is nonzero gets error code 2 (busy) and changes nothing.
- R8: A free of an allocated queue succeeds in the first cycle after the accepting edge. It returns the old word on `rsp_cfg` and its start page on `rsp_page`, clears those pages for reuse and zeroes the queue's word.
- R9: A free of a queue whose word is zero gets error code 1 (invalid).
- R10: `busy` is high from the cycle after an accepted request through the `done` cycle. A `req_valid` seen while busy is ignored.
- R11: `done` is a one-cycle pulse. `ok` is high with it exactly when `err` is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_free | input | 1 | 1 = free the queue, 0 = allocate |
| req_queue | input | 6 | Queue index |
| req_len | input | 8 | Requested length in dwords |
| req_ne_wm | input | 4 | Nearly-empty watermark, valid 0 to 7 |
| req_nf_wm | input | 4 | Nearly-full watermark, valid 0 to 7 |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid this cycle |
| ok | output | 1 | Request succeeded |
| err | output | 2 | 0 none, 1 invalid, 2 busy, 3 out-of-memory |
| rsp_page | output | 8 | Start page of the allocated or freed run |
| rsp_cfg | output | 32 | Configuration word written (allocate) or cleared (free) |

## Verification
The hardest cases to reach are fragmented memory, where a long run must skip several occupied holes before it fits, and the out-of-memory edge, where the last legal start sits just below page 128. Random traffic over a small set of queues mixes allocations of every size with frees, so holes open and close in varied patterns. A directed phase packs memory with 8-page runs until the allocator refuses. A reference bitmap in the bench predicts every start page and search length. One directed case holds `req_valid` for a second request while a search is under way, to show that the second request is dropped.

// File: rtl/qpa_pkg.sv
package qpa_pkg;

    typedef enum logic [1:0] {
        QE_NONE  = 2'd0,
        QE_INVAL = 2'd1,
        QE_BUSY  = 2'd2,
        QE_NOMEM = 2'd3
    } qerr_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SEARCH = 2'd1,
        S_DONE   = 2'd2
    } qstate_e;

    // configuration word field positions (decoded by the queue datapath)
    localparam int CFG_PAGE_LSB = 14;
    localparam int CFG_SIZE_LSB = 24;
    localparam int CFG_NE_LSB   = 26;
    localparam int CFG_NF_LSB   = 29;
    localparam int WM_MAX       = 7;

    function automatic logic [31:0] cfg_pack(input logic [7:0] page,
                                             input logic [1:0] sz,
                                             input logic [2:0] ne,
                                             input logic [2:0] nf);
        logic [31:0] w;
        w = '0;
        w[CFG_PAGE_LSB +: 8] = page;
        w[CFG_SIZE_LSB +: 2] = sz;
        w[CFG_NE_LSB   +: 3] = ne;
        w[CFG_NF_LSB   +: 3] = nf;
        return w;
    endfunction

endpackage

// File: rtl/qpa_cfg_table.sv
module qpa_cfg_table #(
    parameter int NQ = 64,
    parameter int QW = 6,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [QW-1:0] rd_idx,
    output logic [CW-1:0] rd_word,
    input  logic          we,
    input  logic [QW-1:0] wr_idx,
    input  logic [CW-1:0] wr_word
);

    logic [CW-1:0] mem [NQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_word;
        end
    end

    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/qpa_fit_check.sv
module qpa_fit_check #(
    parameter int PAGES = 128,
    parameter int PW    = 8
) (
    input  logic [PAGES-1:0] used,
    input  logic [PW-1:0]    cand,
    input  logic [PW-1:0]    npg,
    output logic             fit,
    output logic             past_end
);

    logic [PAGES-1:0] run;
    logic [PAGES-1:0] win;

    assign run      = (PAGES'(1) << npg) - PAGES'(1);
    assign win      = used >> cand;
    assign fit      = ((win & run) == '0);
    assign past_end = ({1'b0, cand} + {1'b0, npg}) > (PW+1)'(PAGES);

endmodule

// File: rtl/qpa_alloc.sv
module qpa_alloc #(
    parameter int NQ      = 64,
    parameter int PAGES   = 128,
    parameter int PAGE_DW = 16,
    parameter int NCODES  = 4,
    parameter int RSVD    = 4,
    parameter int WMW     = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic                                req_free,
    input  logic [$clog2(NQ)-1:0]               req_queue,
    input  logic [$clog2(PAGE_DW)+NCODES-1:0]   req_len,
    input  logic [WMW-1:0]                      req_ne_wm,
    input  logic [WMW-1:0]                      req_nf_wm,
    output logic                                busy,
    output logic                                done,
    output logic                                ok,
    output logic [1:0]                          err,
    output logic [$clog2(PAGES):0]              rsp_page,
    output logic [31:0]                         rsp_cfg
);
    import qpa_pkg::*;

    localparam int QW   = $clog2(NQ);
    localparam int PW   = $clog2(PAGES) + 1;
    localparam int LENW = $clog2(PAGE_DW) + NCODES;
    localparam int SZW  = 2;

    qstate_e          state_q, state_d;
    logic [PAGES-1:0] used_q;
    logic [PW-1:0]    cand_q;
    logic [SZW-1:0]   code_q;
    logic [QW-1:0]    queue_q;
    logic [2:0]       ne_q, nf_q;
    qerr_e            err_q;
    logic             ok_q;
    logic [PW-1:0]    page_q;
    logic [31:0]      cfg_q;

    // request decode
    logic           len_ok;
    logic [SZW-1:0] len_code;
    always_comb begin
        len_ok   = 1'b0;
        len_code = '0;
        for (int k = 0; k < NCODES; k++) begin
            if (req_len == LENW'(PAGE_DW << k)) begin
                len_ok   = 1'b1;
                len_code = SZW'(k);
            end
        end
    end

    logic [31:0] rd_word;
    logic        acc, alloc_bad, alloc_busy, go_search, free_hit;
    assign acc        = (state_q == S_IDLE) && req_valid;
    assign alloc_bad  = !len_ok || (req_ne_wm > WMW'(WM_MAX)) || (req_nf_wm > WMW'(WM_MAX));
    assign alloc_busy = (rd_word != '0);
    assign go_search  = acc && !req_free && !alloc_bad && !alloc_busy;
    assign free_hit   = acc && req_free && (rd_word != '0);

    // search datapath
    logic [PW-1:0]    npg;
    logic             fit, past_end, commit;
    logic [PAGES-1:0] set_mask;
    logic [31:0]      new_cfg;
    assign npg      = PW'(1) << code_q;
    assign commit   = (state_q == S_SEARCH) && !past_end && fit;
    assign set_mask = ((PAGES'(1) << npg) - PAGES'(1)) << cand_q;
    assign new_cfg  = cfg_pack(8'(cand_q), code_q, ne_q, nf_q);

    qpa_fit_check #(.PAGES(PAGES), .PW(PW)) u_fit (
        .used     (used_q),
        .cand     (cand_q),
        .npg      (npg),
        .fit      (fit),
        .past_end (past_end)
    );

    // free decode from the stored word
    logic [SZW-1:0]   free_code;
    logic [PW-1:0]    free_page, free_npg;
    logic [PAGES-1:0] free_mask;
    assign free_code = rd_word[CFG_SIZE_LSB +: SZW];
    assign free_page = PW'(rd_word[CFG_PAGE_LSB +: 8]);
    assign free_npg  = PW'(1) << free_code;
    assign free_mask = ((PAGES'(1) << free_npg) - PAGES'(1)) << free_page;

    qpa_cfg_table #(.NQ(NQ), .QW(QW), .CW(32)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_queue),
        .rd_word (rd_word),
        .we      (commit || free_hit),
        .wr_idx  (commit ? queue_q : req_queue),
        .wr_word (commit ? new_cfg : 32'd0)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (acc) state_d = go_search ? S_SEARCH : S_DONE;
            S_SEARCH: if (past_end || fit) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q  <= {{(PAGES-RSVD){1'b0}}, {RSVD{1'b1}}};
            cand_q  <= '0;
            code_q  <= '0;
            queue_q <= '0;
            ne_q    <= '0;
            nf_q    <= '0;
            err_q   <= QE_NONE;
            ok_q    <= 1'b0;
            page_q  <= '0;
            cfg_q   <= '0;
        end else begin
            if (acc) begin
                cand_q  <= '0;
                code_q  <= len_code;
                queue_q <= req_queue;
                ne_q    <= req_ne_wm[2:0];
                nf_q    <= req_nf_wm[2:0];
                ok_q    <= 1'b0;
                page_q  <= '0;
                cfg_q   <= '0;
                err_q   <= QE_NONE;
                if (req_free) begin
                    if (free_hit) begin
                        used_q <= used_q & ~free_mask;
                        ok_q   <= 1'b1;
                        page_q <= free_page;
                        cfg_q  <= rd_word;
                    end else begin
                        err_q <= QE_INVAL;
                    end
                end else if (alloc_bad) begin
                    err_q <= QE_INVAL;
                end else if (alloc_busy) begin
                    err_q <= QE_BUSY;
                end
            end
            if (state_q == S_SEARCH) begin
                if (past_end) begin
                    err_q <= QE_NOMEM;
                end else if (fit) begin
                    used_q <= used_q | set_mask;
                    ok_q   <= 1'b1;
                    page_q <= cand_q;
                    cfg_q  <= new_cfg;
                end else begin
                    cand_q <= cand_q + PW'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        done     = (state_q == S_DONE);
        ok       = ok_q;
        err      = err_q;
        rsp_page = page_q;
        rsp_cfg  = cfg_q;
    end

    // checks
    logic [PW-1:0] rsp_npg;
    assign rsp_npg = PW'(1) << cfg_q[CFG_SIZE_LSB +: SZW];

    p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        used_q[RSVD-1:0] == {RSVD{1'b1}});
    p_ok_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (page_q >= PW'(RSVD)));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEARCH) |=> ((state_q != S_SEARCH) || (cand_q == $past(cand_q) + PW'(1))));
    p_fit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (({1'b0, page_q} + {1'b0, rsp_npg}) <= (PW+1)'(PAGES)));
    p_nomem_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_q == QE_NOMEM) |-> (used_q == $past(used_q)));
    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> (queue_q == $past(queue_q)));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/qpa_alloc_tb.sv
module qpa_alloc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 32'h5eed1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_free = 1'b0;
    logic [5:0]  req_queue = '0;
    logic [7:0]  req_len = '0;
    logic [3:0]  req_ne_wm = '0;
    logic [3:0]  req_nf_wm = '0;
    logic        busy, done, ok;
    logic [1:0]  err;
    logic [7:0]  rsp_page;
    logic [31:0] rsp_cfg;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    bit          mb [128];
    logic [31:0] mc [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    qpa_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
        .req_queue(req_queue), .req_len(req_len), .req_ne_wm(req_ne_wm),
        .req_nf_wm(req_nf_wm), .busy(busy), .done(done), .ok(ok), .err(err),
        .rsp_page(rsp_page), .rsp_cfg(rsp_cfg)
    );

    task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!c) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int code_of(input int len);
        for (int k = 0; k < 4; k++) if (len == (16 << k)) return k;
        return -1;
    endfunction

    function automatic int first_fit(input int n);
        for (int s = 0; s + n <= 128; s++) begin
            bit f = 1'b1;
            for (int k = 0; k < n; k++) if (mb[s+k]) f = 1'b0;
            if (f) return s;
        end
        return -1;
    endfunction

    function automatic logic [31:0] pack(input int page, input int code, input int ne, input int nf);
        return (32'(nf) << 29) | (32'(ne) << 26) | (32'(code) << 24) | (32'(page) << 14);
    endfunction

    // one request through the ports, checked against the bitmap model
    task automatic do_op(input bit fr, input int q, input int len, input int ne, input int nf);
        int e_err, e_page, e_lat, code, cnt, n;
        logic [31:0] e_cfg;
        string tag;
        e_page = 0; e_cfg = 0; e_lat = 1; code = code_of(len); n = 0;
        if (fr) begin
            if (mc[q] == 0) begin e_err = 1; tag = "R9"; end
            else begin
                e_err = 0; tag = "R8";
                e_cfg = mc[q]; e_page = int'(mc[q][21:14]);
            end
        end else if (code < 0) begin e_err = 1; tag = "R2";
        end else if (ne > 7 || nf > 7) begin e_err = 1; tag = "R3";
        end else if (mc[q] != 0) begin e_err = 2; tag = "R7";
        end else begin
            n = 1 << code;
            e_page = first_fit(n);
            if (e_page < 0) begin e_err = 3; tag = "R5"; e_page = 0; e_lat = -1; end
            else begin
                e_err = 0; tag = "R4"; e_lat = e_page + 2;
                e_cfg = pack(e_page, code, ne, nf);
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_free = fr; req_queue = 6'(q);
        req_len = 8'(len); req_ne_wm = 4'(ne); req_nf_wm = 4'(nf);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 1;
        while (!done && cnt < 400) begin @(negedge clk); cnt++; end
        chk(err == 2'(e_err), {tag, " err"}, 32'(err), 32'(e_err));
        chk(ok == (e_err == 0), "R11 ok", 32'(ok), 32'(e_err == 0));
        if (e_err == 0) begin
            chk(rsp_page == 8'(e_page), {tag, " page"}, 32'(rsp_page), 32'(e_page));
            chk(rsp_cfg == e_cfg, fr ? "R8 cfg" : "R6 cfg", rsp_cfg, e_cfg);
        end
        if (e_lat >= 0) chk(cnt == e_lat, {tag, " latency"}, 32'(cnt), 32'(e_lat));
        @(negedge clk);
        chk(!done && !busy, "R11 done pulse", {30'd0, done, busy}, 32'd0);
        if (e_err == 0) begin
            if (fr) begin
                for (int k = 0; k < (1 << int'(mc[q][25:24])); k++) mb[e_page+k] = 1'b0;
                mc[q] = 0;
            end else begin
                for (int k = 0; k < n; k++) mb[e_page+k] = 1'b1;
                mc[q] = e_cfg;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int dummy, s, cnt;
        dummy = $urandom(SEED);
        for (int i = 0; i < 128; i++) mb[i] = (i < 4);
        for (int i = 0; i < 64; i++) mc[i] = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 reset", {30'd0, busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", {30'd0, busy, done}, 32'd0);

        // directed corners
        do_op(0, 0, 16, 0, 0);                       // R1: first run at page 4
        chk(mc[0][21:14] == 8'd4, "R1 first page", 32'(mc[0][21:14]), 32'd4);
        do_op(0, 1, 64, 3, 5);                        // R4 and R6
        do_op(0, 2, 48, 0, 0);                        // R2 invalid length
        do_op(0, 2, 0, 0, 0);                         // R2 invalid length
        do_op(0, 2, 32, 8, 0);                        // R3
        do_op(0, 2, 32, 0, 15);                       // R3
        do_op(0, 2, 32, 7, 7);                        // R6 top watermarks
        do_op(0, 0, 16, 1, 1);                        // R7
        do_op(1, 9, 16, 0, 0);                        // R9
        do_op(1, 0, 16, 0, 0);                        // R8
        do_op(0, 3, 16, 0, 0);                        // R8 reuse of freed page 4

        // R10: second request held during a search is dropped
        s = first_fit(1);
        @(negedge clk);
        req_valid = 1'b1; req_free = 1'b0; req_queue = 6'd40; req_len = 8'd16;
        req_ne_wm = 4'd0; req_nf_wm = 4'd0;
        @(negedge clk);
        chk(busy, "R10 busy", 32'(busy), 32'd1);
        req_queue = 6'd41;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 2;
        while (!done && cnt < 400) begin @(negedge clk); cnt++; end
        chk(busy, "R10 busy in done", 32'(busy), 32'd1);
        chk(rsp_page == 8'(s), "R10 page", 32'(rsp_page), 32'(s));
        mb[s] = 1'b1; mc[40] = pack(s, 0, 0, 0);
        @(negedge clk);
        do_op(1, 41, 16, 0, 0);                       // R10: queue 41 untouched

        // R5: pack memory with 8-page runs until refusal
        for (int q = 10; q < 30; q++) do_op(0, q, 128, 2, 6);
        do_op(0, 30, 16, 0, 0);
        do_op(0, 31, 16, 0, 0);
        for (int q = 10; q < 32; q++) do_op(1, q, 16, 0, 0);

        // constrained random traffic
        for (int i = 0; i < 400; i++) begin
            int r, len, ne, nf;
            r = $urandom_range(0, 11);
            if (r < 10) len = 16 << (r % 4);
            else if (r == 10) len = $urandom_range(0, 255);
            else len = 96;
            ne = ($urandom_range(0, 15) == 0) ? $urandom_range(8, 15) : $urandom_range(0, 7);
            nf = ($urandom_range(0, 15) == 0) ? $urandom_range(8, 15) : $urandom_range(0, 7);
            do_op($urandom_range(0, 2) == 0, $urandom_range(0, 15), len, ne, nf);
        end
        for (int q = 0; q < 64; q++) if (mc[q] != 0) do_op(1, q, 16, 0, 0);
        do_op(0, 5, 128, 0, 0);                       // R1: all freed, 8-page run at page 4

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule